// File: doc/BRIEF.md
# Shared ISA Interrupt Routing Matrix

This block collects level-sensitive interrupt requests from the internal functions of a south-bridge model and from four external PCI interrupt pins. It folds them onto sixteen ISA IRQ lines, and any number of sources may share one line. Every change of a source's level arrives as a one-cycle event that carries a function number, a pin index and the new level. The block looks up where that source is routed and updates a per-line bitmask of the sources currently holding the line. Each line output is high while its mask holds any set bit.

Route values live in byte-wide configuration registers that are written through a simple address/data/write-enable port. The four external pins share packed nibble registers. Functions 1 to 7 each have a whole byte. A route can be disabled or illegal. An illegal route raises a sticky error flag and records the first offending source, and software clears the flag through a status write.

Top module: `isa_irq_router`

## Requirements
- R1: Source ids are one bit each in a 16-bit mask. Function f (1..7) uses bit f. Function 0 with pin index p (0..3, pins A..D) uses bit 8+p.
- R2: Every accepted event writes its source's bit in a global state mask to the event level, whatever the route value is.
- R3: The route of function 0 comes from packed nibbles. Pin A reads address 0x55 bits 7:4, pin B reads 0x56 bits 3:0, pin C reads 0x56 bits 7:4, and pin D reads 0x57 bits 7:4. Function f in 1..7 reads the byte at address f.
- R4: A route value of 0x00 or 0xFF disables the source. Only the global mask changes, and no IRQ output changes.
- R5: A route of 2 is illegal for every source, and so is any route above the source's limit. An illegal route sets the error flag and leaves every IRQ output unchanged.
- R6: The limit is 14 for functions 2, 3 and 5, and 15 for all other sources, including the four pins.
- R7: On a legal route r, the source's bit in line r's mask takes the event level. That mask is then ANDed with the updated global mask.
- R8: Output line r is the registered OR of line r's mask. It changes on the clock edge that accepts the event, so it is visible one cycle after the event is presented. Line 0 is always low.
- R9: Bits that a remap leaves behind on a line are removed only when a later legal event targets that same line.
- R10: The error flag is sticky. `err_src` holds the source id of the first illegal event since the flag was last clear. Writing a byte with bit 0 set to address 0x40 clears the flag, but an illegal event in the same cycle wins.
- R11: Synchronous reset clears all masks, all route registers, every output and the error flag.
- R12: `ev_ready` is low during reset and high from the first cycle after it. The block accepts one event per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Source event strobe |
| ev_ready | output | 1 | Event can be accepted |
| ev_func | input | 3 | Function number of the source |
| ev_pin | input | 2 | Pin index (used by function 0) |
| ev_level | input | 1 | New level of the source |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| irq_out | output | 16 | ISA IRQ line levels |
| err_flag | output | 1 | Sticky illegal-route flag |
| err_src | output | 4 | Source id of the first illegal route |

## Verification
The bench builds the block with its default sixteen lines, eight functions and four pins. At that size it can sweep every source through every nibble route and through a spread of byte routes, including 0x00, 0x02, 14, 15, 16, 0x80 and 0xFF. Each point drives the level high and then low, and the expected line pattern and error state are computed arithmetically from the source's limit. Directed sequences then cover sharing between an internal function and a pin, remaps that leave stale bits behind, scrubbing of those bits by a neighbour's event, and the rule that the first illegal source is the one recorded.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;
  // Configuration address map (byte addresses)
  localparam logic [7:0] ADDR_PIRQ_A   = 8'h55;  // pin A route in [7:4]
  localparam logic [7:0] ADDR_PIRQ_BC  = 8'h56;  // pin B in [3:0], pin C in [7:4]
  localparam logic [7:0] ADDR_PIRQ_D   = 8'h57;  // pin D route in [7:4]
  localparam logic [7:0] ADDR_ERR_CLR  = 8'h40;  // write bit 0 = 1 to clear error

  // Functions whose highest legal line is one below the usual top line
  localparam logic [7:0] LOW_LIMIT_FUNCS = 8'b0010_1100; // functions 2, 3, 5

  typedef enum logic [1:0] {
    RT_OFF   = 2'd0,
    RT_LEGAL = 2'd1,
    RT_BAD   = 2'd2
  } route_kind_e;
endpackage

// File: rtl/isa_route_table.sv
module isa_route_table #(
  parameter int NUM_FUNC  = 8,
  parameter int NUM_PIN   = 4,
  parameter int ROUTE_W   = 8,
  parameter int SRC_BITS  = 16,
  parameter int PIRQ_BASE = 8,
  localparam int FUNC_W    = $clog2(NUM_FUNC),
  localparam int PIN_W     = $clog2(NUM_PIN),
  localparam int SRC_IDX_W = $clog2(SRC_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_addr,
  input  logic [ROUTE_W-1:0]   cfg_wdata,
  input  logic [FUNC_W-1:0]    ev_func,
  input  logic [PIN_W-1:0]     ev_pin,
  output logic [ROUTE_W-1:0]   route,
  output logic [SRC_IDX_W-1:0] src_id
);
  import isa_irq_pkg::*;

  logic [ROUTE_W-1:0] fn_route [NUM_FUNC];
  logic [7:0]         pirq_a_q, pirq_bc_q, pirq_d_q;

  // Function 0 has no byte of its own; its slot stays zero
  assign fn_route[0] = '0;

  genvar g;
  generate
    for (g = 1; g < NUM_FUNC; g++) begin : g_fn_reg
      logic [ROUTE_W-1:0] reg_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          reg_q <= '0;
        end else if (cfg_we && cfg_addr == 8'(g)) begin
          reg_q <= cfg_wdata;
        end
      end
      assign fn_route[g] = reg_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pirq_a_q  <= '0;
      pirq_bc_q <= '0;
      pirq_d_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_PIRQ_A)  pirq_a_q  <= cfg_wdata[7:0];
      if (cfg_addr == ADDR_PIRQ_BC) pirq_bc_q <= cfg_wdata[7:0];
      if (cfg_addr == ADDR_PIRQ_D)  pirq_d_q  <= cfg_wdata[7:0];
    end
  end

  logic [3:0] pin_nib;
  always_comb begin
    case (ev_pin)
      2'd0:    pin_nib = pirq_a_q[7:4];
      2'd1:    pin_nib = pirq_bc_q[3:0];
      2'd2:    pin_nib = pirq_bc_q[7:4];
      default: pin_nib = pirq_d_q[7:4];
    endcase
  end

  always_comb begin
    if (ev_func == '0) begin
      route  = ROUTE_W'(pin_nib);
      src_id = SRC_IDX_W'(PIRQ_BASE) + SRC_IDX_W'(ev_pin);
    end else begin
      route  = fn_route[ev_func];
      src_id = SRC_IDX_W'(ev_func);
    end
  end
endmodule

// File: rtl/isa_route_check.sv
module isa_route_check #(
  parameter int NUM_LINES = 16,
  parameter int NUM_FUNC  = 8,
  parameter int ROUTE_W   = 8,
  parameter int RSVD_LINE = 2,
  localparam int FUNC_W   = $clog2(NUM_FUNC),
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [ROUTE_W-1:0]     route,
  input  logic [FUNC_W-1:0]      ev_func,
  output isa_irq_pkg::route_kind_e kind,
  output logic [LINE_W-1:0]      line
);
  import isa_irq_pkg::*;

  localparam int TOP_LINE = NUM_LINES - 1;

  logic                low_lim;
  logic [ROUTE_W-1:0]  limit;
  logic                off;

  assign low_lim = LOW_LIMIT_FUNCS[ev_func];
  assign limit   = low_lim ? ROUTE_W'(TOP_LINE - 1) : ROUTE_W'(TOP_LINE);
  assign off     = (route == '0) || (route == '1);
  assign line    = route[LINE_W-1:0];

  always_comb begin
    if (off) begin
      kind = RT_OFF;
    end else if (route == ROUTE_W'(RSVD_LINE) || route > limit) begin
      kind = RT_BAD;
    end else begin
      kind = RT_LEGAL;
    end
  end
endmodule

// File: rtl/isa_mask_bank.sv
module isa_mask_bank #(
  parameter int NUM_LINES = 16,
  parameter int SRC_BITS  = 16,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int SRC_IDX_W = $clog2(SRC_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic                 apply,
  input  logic [SRC_IDX_W-1:0] src_id,
  input  logic                 level,
  input  logic [LINE_W-1:0]    line,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [SRC_BITS-1:0] src_bit;
  logic [SRC_BITS-1:0] gmask_q, gmask_n;

  assign src_bit = SRC_BITS'(1) << src_id;
  assign gmask_n = level ? (gmask_q | src_bit) : (gmask_q & ~src_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_q <= '0;
    end else if (upd) begin
      gmask_q <= gmask_n;
    end
  end

  // Line 0 is the global slot; it never drives an output
  assign irq_out[0] = 1'b0;

  genvar i;
  generate
    for (i = 1; i < NUM_LINES; i++) begin : g_line
      logic [SRC_BITS-1:0] lmask_q, lmask_n;
      logic                irq_q;
      logic                hit;

      assign hit     = upd && apply && (line == LINE_W'(i));
      assign lmask_n = (level ? (lmask_q | src_bit) : (lmask_q & ~src_bit)) & gmask_n;

      always_ff @(posedge clk) begin
        if (rst) begin
          lmask_q <= '0;
          irq_q   <= 1'b0;
        end else if (hit) begin
          lmask_q <= lmask_n;
          irq_q   <= |lmask_n;
        end
      end
      assign irq_out[i] = irq_q;
    end
  endgenerate
endmodule

// File: rtl/isa_irq_router.sv
module isa_irq_router #(
  parameter int NUM_LINES = 16,
  parameter int NUM_FUNC  = 8,
  parameter int NUM_PIN   = 4,
  parameter int SRC_BITS  = 16,
  parameter int PIRQ_BASE = 8,
  parameter int ROUTE_W   = 8,
  localparam int FUNC_W    = $clog2(NUM_FUNC),
  localparam int PIN_W     = $clog2(NUM_PIN),
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int SRC_IDX_W = $clog2(SRC_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [FUNC_W-1:0]    ev_func,
  input  logic [PIN_W-1:0]     ev_pin,
  input  logic                 ev_level,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_addr,
  input  logic [ROUTE_W-1:0]   cfg_wdata,
  output logic [NUM_LINES-1:0] irq_out,
  output logic                 err_flag,
  output logic [SRC_IDX_W-1:0] err_src
);
  import isa_irq_pkg::*;

  logic                 ready_q;
  logic                 ev_acc;
  logic [ROUTE_W-1:0]   rt_route;
  logic [SRC_IDX_W-1:0] rt_src;
  route_kind_e          rt_kind;
  logic [LINE_W-1:0]    rt_line;
  logic                 err_q;
  logic [SRC_IDX_W-1:0] err_src_q;
  logic                 err_clr;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign ev_ready = ready_q;
  assign ev_acc   = ev_valid && ready_q;

  isa_route_table #(
    .NUM_FUNC(NUM_FUNC), .NUM_PIN(NUM_PIN), .ROUTE_W(ROUTE_W),
    .SRC_BITS(SRC_BITS), .PIRQ_BASE(PIRQ_BASE)
  ) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ev_func(ev_func), .ev_pin(ev_pin),
    .route(rt_route), .src_id(rt_src)
  );

  isa_route_check #(
    .NUM_LINES(NUM_LINES), .NUM_FUNC(NUM_FUNC), .ROUTE_W(ROUTE_W)
  ) u_check (
    .route(rt_route), .ev_func(ev_func), .kind(rt_kind), .line(rt_line)
  );

  isa_mask_bank #(
    .NUM_LINES(NUM_LINES), .SRC_BITS(SRC_BITS)
  ) u_masks (
    .clk(clk), .rst(rst),
    .upd(ev_acc), .apply(rt_kind == RT_LEGAL),
    .src_id(rt_src), .level(ev_level), .line(rt_line),
    .irq_out(irq_out)
  );

  assign err_clr = cfg_we && (cfg_addr == ADDR_ERR_CLR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= 1'b0;
      err_src_q <= '0;
    end else if (ev_acc && rt_kind == RT_BAD) begin
      err_q <= 1'b1;
      if (!err_q) err_src_q <= rt_src;
    end else if (err_clr) begin
      err_q <= 1'b0;
    end
  end
  assign err_flag = err_q;
  assign err_src  = err_src_q;
endmodule

// File: rtl/isa_irq_router_chk.sv
module isa_irq_router_chk #(
  parameter int NUM_LINES = 16,
  parameter int SRC_BITS  = 16,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int SRC_IDX_W = $clog2(SRC_BITS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ev_acc,
  input logic                 ev_level,
  input logic [1:0]           rt_kind,
  input logic [LINE_W-1:0]    rt_line,
  input logic                 err_clr,
  input logic [NUM_LINES-1:0] irq_out,
  input logic                 err_flag,
  input logic [SRC_IDX_W-1:0] err_src
);
  AST_OFF_HOLDS_LINES: assert property (@(posedge clk) disable iff (rst)
    (ev_acc && rt_kind == 2'd0) |=> $stable(irq_out)); // R4

  AST_BAD_HOLDS_LINES: assert property (@(posedge clk) disable iff (rst)
    (ev_acc && rt_kind == 2'd2) |=> $stable(irq_out)); // R5

  AST_BAD_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ev_acc && rt_kind == 2'd2) |=> err_flag); // R5

  AST_LEGAL_HIGH_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (ev_acc && rt_kind == 2'd1 && ev_level) |=> irq_out[$past(rt_line)]); // R7

  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !ev_acc |=> $stable(irq_out)); // R8

  AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out ^ $past(irq_out)) <= 1); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag); // R10

  AST_FIRST_SRC_KEPT: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(err_src)); // R10
endmodule

bind isa_irq_router isa_irq_router_chk #(
  .NUM_LINES(NUM_LINES), .SRC_BITS(SRC_BITS)
) u_chk (
  .clk(clk), .rst(rst), .ev_acc(ev_acc), .ev_level(ev_level),
  .rt_kind(rt_kind), .rt_line(rt_line), .err_clr(err_clr),
  .irq_out(irq_out), .err_flag(err_flag), .err_src(err_src)
);

// File: tb/isa_irq_router_test.sv
module isa_irq_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [2:0]  ev_func = '0;
  logic [1:0]  ev_pin = '0;
  logic        ev_level = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] irq_out;
  logic        err_flag;
  logic [3:0]  err_src;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] sh_a = '0, sh_bc = '0, sh_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_irq_router uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_func(ev_func), .ev_pin(ev_pin), .ev_level(ev_level),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_out(irq_out), .err_flag(err_flag), .err_src(err_src)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    sh_a = '0; sh_bc = '0; sh_d = '0;
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // src 1..7: function; src 8..11: function 0 pin src-8
  task automatic set_route(int src, logic [7:0] r);
    case (src)
      8:  begin sh_a  = {r[3:0], sh_a[3:0]};   cfg_write(8'h55, sh_a);  end
      9:  begin sh_bc = {sh_bc[7:4], r[3:0]};  cfg_write(8'h56, sh_bc); end
      10: begin sh_bc = {r[3:0], sh_bc[3:0]};  cfg_write(8'h56, sh_bc); end
      11: begin sh_d  = {r[3:0], sh_d[3:0]};   cfg_write(8'h57, sh_d);  end
      default: cfg_write(8'(src), r);
    endcase
  endtask

  task automatic send(int src, logic lvl);
    @(negedge clk);
    ev_valid = 1'b1; ev_level = lvl;
    if (src >= 8) begin ev_func = 3'd0; ev_pin = 2'(src - 8); end
    else begin ev_func = 3'(src); ev_pin = 2'd0; end
    @(negedge clk); ev_valid = 1'b0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R11 / R12: reset state
    check("R11 irq after reset", 32'(irq_out), 0);
    check("R11 err after reset", 32'(err_flag), 0);
    check("R12 ready after reset", 32'(ev_ready), 1);
    send(1, 1'b1);
    check("R11 routes zero after reset", 32'(irq_out), 0);
    send(1, 1'b0);

    // R1 R3 R4 R5 R6 R7 R8: sweep every source over many routes
    for (int src = 1; src <= 11; src++) begin
      int nvals;
      nvals = (src >= 8) ? 16 : 20;
      for (int v = 0; v < nvals; v++) begin
        logic [7:0] r;
        int lim;
        logic legal, off, bad;
        logic [15:0] exp_hi;
        r = (v < 18) ? 8'(v) : ((v == 18) ? 8'h80 : 8'hFF);
        lim = (src == 2 || src == 3 || src == 5) ? 14 : 15;
        off = (r == 8'h00) || (r == 8'hFF);
        bad = !off && (r == 8'd2 || int'(r) > lim);
        legal = !off && !bad;
        exp_hi = legal ? (16'h1 << r[3:0]) : 16'h0;
        set_route(src, r);
        send(src, 1'b1);
        check($sformatf("R6 R7 R8 src%0d route%0d high", src, r), 32'(irq_out), 32'(exp_hi));
        check($sformatf("R5 src%0d route%0d flag", src, r), 32'(err_flag), 32'(bad));
        if (bad) check($sformatf("R10 src%0d err_src", src), 32'(err_src), 32'(src));
        send(src, 1'b0);
        check($sformatf("R4 R7 src%0d route%0d low", src, r), 32'(irq_out), 0);
        if (bad) begin
          cfg_write(8'h40, 8'h01);
          check("R10 clear", 32'(err_flag), 0);
        end
      end
      set_route(src, 8'h00);
    end

    // R1 R7: function and pin share a line
    do_reset();
    set_route(1, 8'd10);
    set_route(9, 8'd10);
    send(1, 1'b1); send(9, 1'b1);
    check("R7 shared both high", 32'(irq_out), 32'h0400);
    send(1, 1'b0);
    check("R7 shared one left", 32'(irq_out), 32'h0400);
    send(9, 1'b0);
    check("R7 shared both low", 32'(irq_out), 0);

    // R9: stale bit after remap persists, then scrubbed
    set_route(3, 8'd5);
    send(3, 1'b1);
    set_route(3, 8'd7);
    send(3, 1'b1);
    check("R9 both lines high", 32'(irq_out), 32'h00A0);
    send(3, 1'b0);
    check("R9 stale line5 kept", 32'(irq_out), 32'h0020);
    set_route(4, 8'd5);
    send(4, 1'b0);
    check("R9 stale line5 scrubbed", 32'(irq_out), 0);

    // R2: global mask written while route disabled
    set_route(6, 8'd12);
    send(6, 1'b1);
    set_route(6, 8'hFF);
    send(6, 1'b0);
    check("R4 disabled keeps line12", 32'(irq_out), 32'h1000);
    set_route(7, 8'd12);
    send(7, 1'b0);
    check("R2 global cleared while disabled", 32'(irq_out), 0);

    // R10: first illegal source recorded, sticky
    set_route(2, 8'd15);
    set_route(1, 8'd2);
    send(2, 1'b1);
    send(1, 1'b1);
    check("R10 flag sticky", 32'(err_flag), 1);
    check("R10 first source", 32'(err_src), 2);
    cfg_write(8'h40, 8'h00);
    check("R10 clear needs bit0", 32'(err_flag), 1);
    cfg_write(8'h40, 8'h01);
    check("R10 cleared", 32'(err_flag), 0);
    check("R5 no line moved", 32'(irq_out), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule